// File: doc/BRIEF.md
# Dual-Width SECDED Memory Codec

This block protects a memory data path with a single-error-correct, double-error-detect code. One mode select picks the width at run time. In wide mode, each 32-bit word is covered by 7 check bits. In narrow mode, each 16-bit half-word is covered by 6 check bits.

On the write side, the check bits are produced combinationally from the outgoing data, so the memory can store them next to it. On the read side, the data and the stored check bits are taken in together, and the syndrome is recomputed. The block then either repairs one flipped bit or reports that two bits were flipped. The result is presented one clock later with a valid strobe. The flags are aligned to that strobe.

A sticky map keeps one bit per data bit position. It records every data position that has ever been repaired, until it is cleared. Software can read it to tell scattered upsets from a stuck data line.

Top module: `secded_codec`

## Requirements
- R1: With `wide_mode_i`=1 and `ecc_en_i`=1, the code works as follows. Data bit i is placed at the i-th codeword position, counting upward from 1, that is not a power of two (positions 1..38). `wr_chk_o[k]` for k=0..5 is the XOR of the data bits whose position has bit k set. `wr_chk_o[6]` is the XOR of all 32 data bits and `wr_chk_o[5:0]`. The output is combinational.
- R2: With `wide_mode_i`=0 and `ecc_en_i`=1, the same placement is used over `wr_data_i[15:0]` (positions 1..21). `wr_chk_o[4:0]` are the Hamming bits. `wr_chk_o[5]` is the overall parity, and `wr_chk_o[6]` is 0.
- R3: With `ecc_en_i`=0, `wr_chk_o` is 0.
- R4: When `ecc_en_i`=0 or `verify_dis_i`=1, a read returns `rd_data_i` unchanged, and `ce_o` and `ue_o` stay 0 whatever the check bits hold.
- R5: A read accepted on `rd_valid_i` appears on `rd_data_o` with `rd_valid_o`=1 exactly one clock later. For an error-free codeword, the data is unchanged and no flag is raised.
- R6: When checking is on and exactly one data bit is flipped, `rd_data_o` carries the repaired data and `ce_o` pulses together with `rd_valid_o`.
- R7: A single flipped check bit raises `ce_o`. The data is returned as received, and the distribution map is not changed.
- R8: When two bits of the codeword are flipped, `ue_o` pulses and `ce_o` stays 0. `rd_data_o` carries the received data with no bit altered.
- R9: Each repaired data bit position i sets `dist_map_o[i]`. Bits stay set, and later repairs are ORed in. After reset the map is 0.
- R10: `dist_clr_i`=1 clears `dist_map_o` on the next edge. This takes priority over a repair in the same cycle.
- R11: In narrow mode, `rd_data_o[31:16]` follows `rd_data_i[31:16]` unchanged, and `rd_chk_i[6]` is ignored.
- R12: With `rd_valid_i`=0, the next cycle has `rd_valid_o`=0, `ce_o`=`ue_o`=0, and `rd_data_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wide_mode_i | input | 1 | 1: 32-bit quantum, 0: 16-bit quantum |
| ecc_en_i | input | 1 | Code generation and checking enable |
| verify_dis_i | input | 1 | 1 disables read checking |
| wr_data_i | input | 32 | Data being written |
| wr_chk_o | output | 7 | Check bits for `wr_data_i` |
| rd_valid_i | input | 1 | Read codeword present |
| rd_data_i | input | 32 | Read data from memory |
| rd_chk_i | input | 7 | Stored check bits from memory |
| rd_valid_o | output | 1 | Corrected read data valid |
| rd_data_o | output | 32 | Corrected read data |
| ce_o | output | 1 | Correctable error pulse |
| ue_o | output | 1 | Uncorrectable error pulse |
| dist_clr_i | input | 1 | Clear the distribution map |
| dist_map_o | output | 32 | Sticky map of repaired data bit positions |

## Verification
The hardest case to reach from the ports is a map clear that lands in the same cycle as a repair. Next to it are the single errors that fall in each check bit, including the overall parity bit, which must flag without touching data or map. The bench encodes clean data with its own model, then flips chosen codeword bits. It walks every data and check position in both widths and issues a clear together with a flipped data bit. The expected outcome is derived from how many bits it flipped, not from any syndrome arithmetic.

// File: rtl/secded_pkg.sv
package secded_pkg;
  localparam int WIDE_DW = 32;
  localparam int WIDE_PW = 6;
  localparam int NARR_DW = 16;
  localparam int NARR_PW = 5;
  localparam int MAX_DW  = WIDE_DW;
  localparam int MAX_PW  = WIDE_PW;

  typedef enum logic {MODE_NARROW = 1'b0, MODE_WIDE = 1'b1} width_mode_e;

  // Codeword position of data bit idx: idx-th non-power-of-two position from 1
  function automatic int data_pos(int idx);
    int cnt;
    cnt = -1;
    for (int p = 1; p < 64; p++) begin
      if ((p & (p - 1)) != 0) begin
        cnt++;
        if (cnt == idx) return p;
      end
    end
    return 0;
  endfunction

  function automatic logic [MAX_PW-1:0] ham_bits(logic [MAX_DW-1:0] d, int dw, int pw);
    logic [MAX_PW-1:0] h;
    h = '0;
    for (int k = 0; k < MAX_PW; k++) begin
      for (int i = 0; i < MAX_DW; i++) begin
        if (k < pw && i < dw && ((data_pos(i) >> k) & 1) == 1) h[k] = h[k] ^ d[i];
      end
    end
    return h;
  endfunction
endpackage

// File: rtl/secded_enc.sv
module secded_enc
  import secded_pkg::*;
#(
  parameter int DW = 32,
  parameter int PW = 6
) (
  input  logic [DW-1:0] data_i,
  output logic [PW:0]   chk_o
);
  logic [MAX_DW-1:0] d_ext;
  logic [MAX_PW-1:0] h_all;

  always_comb begin
    d_ext = '0;
    d_ext[DW-1:0] = data_i;
    h_all = ham_bits(d_ext, DW, PW);
    chk_o[PW-1:0] = h_all[PW-1:0];
    chk_o[PW] = ^data_i ^ ^h_all[PW-1:0];
  end
endmodule

// File: rtl/secded_dec.sv
module secded_dec
  import secded_pkg::*;
#(
  parameter int DW = 32,
  parameter int PW = 6
) (
  input  logic [DW-1:0] data_i,
  input  logic [PW:0]   chk_i,
  output logic [DW-1:0] data_o,
  output logic [DW-1:0] flip_o,
  output logic          single_o,
  output logic          double_o
);
  logic [MAX_DW-1:0] d_ext;
  logic [MAX_PW-1:0] h_all;
  logic [PW-1:0]     synd;
  logic              par_err;

  always_comb begin
    d_ext = '0;
    d_ext[DW-1:0] = data_i;
    h_all = ham_bits(d_ext, DW, PW);
    synd = h_all[PW-1:0] ^ chk_i[PW-1:0];
    par_err = ^data_i ^ ^chk_i;
    single_o = par_err;
    double_o = !par_err && (synd != '0);
    for (int i = 0; i < DW; i++) begin
      flip_o[i] = par_err && (int'(synd) == data_pos(i));
    end
    data_o = data_i ^ flip_o;
  end
endmodule

// File: rtl/secded_codec.sv
module secded_codec
  import secded_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wide_mode_i,
  input  logic        ecc_en_i,
  input  logic        verify_dis_i,
  input  logic [31:0] wr_data_i,
  output logic [6:0]  wr_chk_o,
  input  logic        rd_valid_i,
  input  logic [31:0] rd_data_i,
  input  logic [6:0]  rd_chk_i,
  output logic        rd_valid_o,
  output logic [31:0] rd_data_o,
  output logic        ce_o,
  output logic        ue_o,
  input  logic        dist_clr_i,
  output logic [31:0] dist_map_o
);
  localparam int NUP = WIDE_DW - NARR_DW;

  logic [WIDE_PW:0]    w_chk;
  logic [NARR_PW:0]    n_chk;
  logic [WIDE_DW-1:0]  w_data, w_flip;
  logic [NARR_DW-1:0]  n_data, n_flip;
  logic                w_single, w_double, n_single, n_double;
  logic                check_on;
  width_mode_e         mode;
  logic [WIDE_DW-1:0]  sel_data, sel_flip;
  logic                sel_ce, sel_ue;

  assign mode = width_mode_e'(wide_mode_i);

  secded_enc #(.DW(WIDE_DW), .PW(WIDE_PW)) i_enc_wide (
    .data_i(wr_data_i), .chk_o(w_chk));
  secded_enc #(.DW(NARR_DW), .PW(NARR_PW)) i_enc_narr (
    .data_i(wr_data_i[NARR_DW-1:0]), .chk_o(n_chk));

  secded_dec #(.DW(WIDE_DW), .PW(WIDE_PW)) i_dec_wide (
    .data_i(rd_data_i), .chk_i(rd_chk_i), .data_o(w_data), .flip_o(w_flip),
    .single_o(w_single), .double_o(w_double));
  secded_dec #(.DW(NARR_DW), .PW(NARR_PW)) i_dec_narr (
    .data_i(rd_data_i[NARR_DW-1:0]), .chk_i(rd_chk_i[NARR_PW:0]), .data_o(n_data),
    .flip_o(n_flip), .single_o(n_single), .double_o(n_double));

  always_comb begin
    if (!ecc_en_i)              wr_chk_o = '0;
    else if (mode == MODE_WIDE) wr_chk_o = w_chk;
    else                        wr_chk_o = {1'b0, n_chk};
  end

  assign check_on = ecc_en_i && !verify_dis_i;

  always_comb begin
    sel_data = rd_data_i;
    sel_flip = '0;
    sel_ce   = 1'b0;
    sel_ue   = 1'b0;
    if (check_on) begin
      if (mode == MODE_WIDE) begin
        sel_data = w_data;
        sel_flip = w_flip;
        sel_ce   = w_single;
        sel_ue   = w_double;
      end else begin
        sel_data = {rd_data_i[WIDE_DW-1:NARR_DW], n_data};
        sel_flip = {{NUP{1'b0}}, n_flip};
        sel_ce   = n_single;
        sel_ue   = n_double;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
      ce_o       <= 1'b0;
      ue_o       <= 1'b0;
    end else begin
      rd_valid_o <= rd_valid_i;
      ce_o       <= rd_valid_i && sel_ce;
      ue_o       <= rd_valid_i && sel_ue;
      if (rd_valid_i) rd_data_o <= sel_data;
    end
  end

  // clear wins over a same-cycle repair
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         dist_map_o <= '0;
    else if (dist_clr_i) dist_map_o <= '0;
    else if (rd_valid_i) dist_map_o <= dist_map_o | sel_flip;
  end

  assert_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ce_o && ue_o));
  assert_flag_valid_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_o || ue_o) |-> rd_valid_o);
  assert_idle_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_valid_i |=> (!rd_valid_o && $stable(rd_data_o)));
  assert_latency_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_i |=> rd_valid_o);
  assert_bypass_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_i && !check_on) |=> (rd_data_o == $past(rd_data_i) && !ce_o && !ue_o));
  assert_one_flip_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_flip));
  assert_double_noflip_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_ue |-> (sel_flip == '0));
  assert_map_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dist_clr_i |=> ((dist_map_o & $past(dist_map_o)) == $past(dist_map_o)));
  assert_map_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dist_clr_i |=> (dist_map_o == '0));
endmodule

// File: tb/test_secded_codec.sv
module test_secded_codec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wide_mode = 1'b1, ecc_en = 1'b1, verify_dis = 1'b0;
  logic [31:0] wr_data = '0;
  logic [6:0]  wr_chk;
  logic        rd_valid_in = 1'b0;
  logic [31:0] rd_data_in = '0;
  logic [6:0]  rd_chk_in = '0;
  logic        rd_valid_out, ce, ue, dist_clr = 1'b0;
  logic [31:0] rd_data_out, dist_map;

  always #10 clk = ~clk;

  secded_codec i_secded_codec (
    .clk_i(clk), .rst_ni(rst_n), .wide_mode_i(wide_mode), .ecc_en_i(ecc_en),
    .verify_dis_i(verify_dis), .wr_data_i(wr_data), .wr_chk_o(wr_chk),
    .rd_valid_i(rd_valid_in), .rd_data_i(rd_data_in), .rd_chk_i(rd_chk_in),
    .rd_valid_o(rd_valid_out), .rd_data_o(rd_data_out), .ce_o(ce), .ue_o(ue),
    .dist_clr_i(dist_clr), .dist_map_o(dist_map));

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  logic [31:0] e_data = '0, e_map = '0;
  logic        e_valid = 1'b0, e_ce = 1'b0, e_ue = 1'b0;

  function automatic logic [6:0] ref_chk(logic [31:0] d, bit wide);
    int dw, pw, n, idx;
    logic cw [0:63];
    logic [6:0] r;
    logic par;
    dw = wide ? 32 : 16;
    pw = wide ? 6 : 5;
    n = dw + pw;
    idx = 0;
    r = '0;
    par = 1'b0;
    for (int p = 0; p < 64; p++) cw[p] = 1'b0;
    for (int p = 1; p <= n; p++) begin
      if ((p & (p - 1)) != 0) begin cw[p] = d[idx]; idx++; end
    end
    for (int k = 0; k < pw; k++)
      for (int p = 1; p <= n; p++)
        if ((p >> k) & 1) r[k] = r[k] ^ cw[p];
    for (int i = 0; i < dw; i++) par = par ^ d[i];
    for (int k = 0; k < pw; k++) par = par ^ r[k];
    r[pw] = par;
    return r;
  endfunction

  task automatic cmp(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // one clock: drive at negedge, check comb write path, then registered outputs
  task automatic step(string req, bit wide, bit en, bit vdis, bit vld, bit clr,
                      logic [31:0] d, logic [31:0] dm, logic [6:0] cm, logic [15:0] up);
    logic [31:0] rdat;
    logic [6:0]  good;
    int errs, pw;
    bit on;
    pw = wide ? 6 : 5;
    if (!wide) dm[31:16] = '0;
    good = ref_chk(d, wide);
    rdat = wide ? (d ^ dm) : {up, d[15:0] ^ dm[15:0]};
    wide_mode = wide; ecc_en = en; verify_dis = vdis;
    wr_data = d; rd_valid_in = vld; dist_clr = clr;
    rd_data_in = rdat;
    rd_chk_in = good ^ cm;
    #1;
    cmp(en ? (wide ? "R1" : "R2") : "R3", "wr_chk", {25'd0, wr_chk},
        {25'd0, en ? good : 7'd0});
    errs = $countones(dm);
    for (int k = 0; k <= pw; k++) errs += int'(cm[k]);
    on = en && !vdis;
    e_valid = vld; e_ce = 1'b0; e_ue = 1'b0;
    if (vld) begin
      e_data = rdat;
      if (on && errs == 1) begin
        e_data = rdat ^ dm;
        e_ce = 1'b1;
      end else if (on && errs == 2) begin
        e_ue = 1'b1;
      end
    end
    if (clr) e_map = '0;
    else if (vld && on && errs == 1) e_map = e_map | dm;
    @(posedge clk);
    @(negedge clk);
    cmp(req, "rd_valid", {31'd0, rd_valid_out}, {31'd0, e_valid});
    cmp(req, "rd_data", rd_data_out, e_data);
    cmp(req, "ce", {31'd0, ce}, {31'd0, e_ce});
    cmp(req, "ue", {31'd0, ue}, {31'd0, e_ue});
    cmp(clr ? "R10" : "R9", "dist_map", dist_map, e_map);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    #35;
    @(negedge clk);
    cmp("R5", "reset rd_valid", {31'd0, rd_valid_out}, 32'd0);
    cmp("R5", "reset rd_data", rd_data_out, 32'd0);
    cmp("R9", "reset dist_map", dist_map, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // clean reads
    for (int i = 0; i < 20; i++) step("R5", 1, 1, 0, 1, 0, $urandom, 0, 0, 0);
    for (int i = 0; i < 20; i++)
      step("R11", 0, 1, 0, 1, 0, $urandom, 0, {$urandom % 2 == 1, 6'd0}, 16'($urandom));
    // single data-bit errors at every position
    for (int b = 0; b < 32; b++) step("R6", 1, 1, 0, 1, 0, $urandom, 32'd1 << b, 0, 0);
    step("R10", 1, 1, 0, 1, 1, $urandom, 0, 0, 0);
    for (int b = 0; b < 16; b++)
      step("R6", 0, 1, 0, 1, 0, $urandom, 32'd1 << b, 0, 16'($urandom));
    // single check-bit errors
    for (int b = 0; b < 7; b++) step("R7", 1, 1, 0, 1, 0, $urandom, 0, 7'd1 << b, 0);
    for (int b = 0; b < 6; b++) step("R7", 0, 1, 0, 1, 0, $urandom, 0, 7'd1 << b, 0);
    // double errors
    for (int i = 0; i < 40; i++) begin
      bit wide;
      int tot, a, c;
      logic [31:0] dm;
      logic [6:0] cm;
      wide = (i % 2 == 0);
      tot = wide ? 39 : 22;
      a = $urandom % tot;
      c = (a + 1 + ($urandom % (tot - 1))) % tot;
      dm = '0; cm = '0;
      if (a < tot - (wide ? 7 : 6)) dm[a] = 1'b1; else cm[a - (tot - (wide ? 7 : 6))] = 1'b1;
      if (c < tot - (wide ? 7 : 6)) dm[c] = 1'b1; else cm[c - (tot - (wide ? 7 : 6))] = 1'b1;
      step("R8", wide, 1, 0, 1, 0, $urandom, dm, cm, 16'($urandom));
    end
    // checking bypassed
    for (int i = 0; i < 10; i++)
      step("R4", i % 2 == 0, 0, 0, 1, 0, $urandom, 32'd1 << (i % 16), 0, 16'($urandom));
    for (int i = 0; i < 10; i++)
      step("R4", i % 2 == 0, 1, 1, 1, 0, $urandom, 32'd3 << (i % 16), 0, 16'($urandom));
    // idle cycles hold data and raise no flags
    for (int i = 0; i < 6; i++) step("R12", 1, 1, 0, 0, 0, $urandom, 32'd1, 0, 0);
    // accumulate then clear together with a repair
    step("R9", 1, 1, 0, 1, 0, $urandom, 32'h0000_0100, 0, 0);
    step("R9", 1, 1, 0, 1, 0, $urandom, 32'h8000_0000, 0, 0);
    step("R10", 1, 1, 0, 1, 1, $urandom, 32'h0000_0010, 0, 0);
    step("R9", 0, 1, 0, 1, 0, $urandom, 32'h0000_0004, 0, 0);
    step("R10", 1, 1, 0, 0, 1, $urandom, 0, 0, 0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule